// File: doc/BRIEF.md
# CPU Exception Detection and Vectoring Unit

This unit is the exception front end of a 32-bit load/store RISC core. Each cycle it screens the current load or store: a halfword access must sit on an even byte address, a word access on a four-byte boundary, and the address must fall inside one of the populated regions of the memory map. It also receives decoded illegal-instruction, trap and system-call indications from the decoder and an expiry request from the tick timer. When several causes are present at once, it picks one by fixed priority.

When a cause is accepted, the unit acts on the next clock edge. It copies the PC and the live status word into shadow registers, sets the supervisor bit in the status word, and presents the cause's fixed vector on its PC-redirect output. The handler therefore fetches in the following cycle. A return-from-exception request copies both shadow registers back and redirects the PC to the saved address, which also restores the earlier user or supervisor mode. The core writes the status word through a plain write strobe. The unit keeps that register because the entry and return paths must modify it in the same cycle.

Top module: `exc_vector_unit`

## Requirements
- R1: With `memValid` high, an access is misaligned when `memSize`=2'b01 (halfword) and address bit 0 is 1, or when `memSize`[1] is 1 (2'b10 word; 2'b11 is treated as word) and address bits [1:0] are not 2'b00. A byte access (2'b00) is never misaligned. A misaligned access takes cause 2 with vector 0x600.
- R2: With `memValid` high, an address outside every populated region takes cause 1 with vector 0x200. The default regions are 0x0000_0000–0x0002_FFFF, 0x0200_0000–0x0200_0FFF and 0x0400_0000–0x0400_7FFF.
- R3: Exactly one cause is taken, in this priority order from highest to lowest: bus error (1), alignment (2), illegal instruction (3), trap (4), system call (5), timer tick (6).
- R4: The vectors are 0x200 for bus error, 0x600 for alignment, 0x700 for illegal instruction, 0xE00 for trap, 0xC00 for system call and 0x500 for timer tick.
- R5: The saved PC is `nextPc` for a system call and `curPc` for every other cause.
- R6: In the cycle after a request, `pcLoad` and `excTaken` are 1, `pcOut` holds the vector and `excCause` holds the cause code. `esr` holds the status value from before entry, and `status` keeps its other bits with bit 0 (supervisor) set.
- R7: A return request with no exception in the same cycle restores `status` from `esr` and redirects: in the next cycle `pcLoad`=1, `excTaken`=0 and `pcOut`=`epc`.
- R8: After reset, `status`=8'h01 (supervisor), `pcLoad`=0, `excTaken`=0, `excCause`=0, and `epc` and `esr` are 0.
- R9: An exception takes precedence over a return request and over a status write in the same cycle. A status write with neither of them present loads `statusWdata` at the next edge.
- R10: When `memValid` is low, `memAddr` and `memSize` have no effect, and `pcLoad` stays 0 when no other request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| memValid | input | 1 | A load or store is issued this cycle |
| memAddr | input | 32 | Byte address of the access |
| memSize | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| illegalInstr | input | 1 | Decoder found an unrecognised instruction |
| trapReq | input | 1 | Trap instruction executing |
| sysCall | input | 1 | System-call instruction executing |
| tickIrq | input | 1 | Tick timer expiry request |
| eretReq | input | 1 | Return-from-exception instruction executing |
| statusWe | input | 1 | Core writes the status word |
| statusWdata | input | 8 | Value for the status write |
| curPc | input | 32 | Address of the current instruction |
| nextPc | input | 32 | Address of the following instruction |
| pcLoad | output | 1 | Redirect the fetch PC this cycle |
| pcOut | output | 32 | Redirect target (vector or restored PC) |
| excTaken | output | 1 | The redirect is an exception entry |
| excCause | output | 3 | Code of the cause taken |
| status | output | 8 | Live status word, bit 0 is supervisor mode |
| epc | output | 32 | Shadow copy of the PC |
| esr | output | 8 | Shadow copy of the status word |

## Verification
A return request and a timer tick can arrive in the same cycle. The bench first drops to user mode, enters and leaves an exception, and then raises `eretReq` and `tickIrq` together. It expects entry to the tick vector with `epc` equal to the return instruction's address, `esr` equal to the user-mode status and supervisor mode set, and it checks that no restore took place. A single access that is both unpopulated and misaligned is applied the same way, and the bench expects the bus-error vector over the alignment vector.

// File: rtl/excPkg.sv
package excPkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_BUS     = 3'd1,
    CAUSE_ALIGN   = 3'd2,
    CAUSE_ILLEGAL = 3'd3,
    CAUSE_TRAP    = 3'd4,
    CAUSE_SYSCALL = 3'd5,
    CAUSE_TICK    = 3'd6
  } excCause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      take;
    logic      ret;
    logic      wrStatus;
    logic      saveNext;
    excCause_e cause;
  } excStrobe_t;

  function automatic logic [31:0] vectorOf(excCause_e c);
    case (c)
      CAUSE_BUS:     vectorOf = 32'h0000_0200;
      CAUSE_TICK:    vectorOf = 32'h0000_0500;
      CAUSE_ALIGN:   vectorOf = 32'h0000_0600;
      CAUSE_ILLEGAL: vectorOf = 32'h0000_0700;
      CAUSE_SYSCALL: vectorOf = 32'h0000_0C00;
      CAUSE_TRAP:    vectorOf = 32'h0000_0E00;
      default:       vectorOf = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
#(
  parameter int AW = 32,
  parameter int NREG = 3,
  parameter logic [NREG*AW-1:0] REG_BASE = {32'h0400_0000, 32'h0200_0000, 32'h0000_0000},
  parameter logic [NREG*AW-1:0] REG_LAST = {32'h0400_7FFF, 32'h0200_0FFF, 32'h0002_FFFF}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          memValid,
  input  logic [AW-1:0] memAddr,
  input  logic [1:0]    memSize,
  input  logic          illegalInstr,
  input  logic          trapReq,
  input  logic          sysCall,
  input  logic          tickIrq,
  input  logic          eretReq,
  input  logic          statusWe,
  output excStrobe_t    strobe
);

  logic [NREG-1:0] regionHit;
  logic            busErr;
  logic            misAlign;
  excCause_e       cause;

  // one comparator pair per populated region
  for (genvar g = 0; g < NREG; g++) begin : gRegion
    assign regionHit[g] = (memAddr >= REG_BASE[g*AW +: AW]) &&
                          (memAddr <= REG_LAST[g*AW +: AW]);
  end

  assign busErr   = memValid && !(|regionHit);
  assign misAlign = memValid &&
                    (((memSize == 2'b01) && memAddr[0]) ||
                     (memSize[1] && (memAddr[1:0] != 2'b00)));

  always_comb begin
    if (busErr)            cause = CAUSE_BUS;
    else if (misAlign)     cause = CAUSE_ALIGN;
    else if (illegalInstr) cause = CAUSE_ILLEGAL;
    else if (trapReq)      cause = CAUSE_TRAP;
    else if (sysCall)      cause = CAUSE_SYSCALL;
    else if (tickIrq)      cause = CAUSE_TICK;
    else                   cause = CAUSE_NONE;
  end

  always_comb begin
    strobe.cause    = cause;
    strobe.take     = (cause != CAUSE_NONE);
    strobe.ret      = eretReq && (cause == CAUSE_NONE);
    strobe.wrStatus = statusWe && !eretReq && (cause == CAUSE_NONE);
    strobe.saveNext = (cause == CAUSE_SYSCALL);
  end

  // R1
  word_misalign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memSize == 2'b10 && memAddr[1:0] != 2'b00) |-> strobe.take);

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memValid && !illegalInstr && !trapReq && !sysCall && !tickIrq) |-> !strobe.take);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.take, strobe.ret, strobe.wrStatus}));

endmodule

// File: rtl/excState.sv
module excState
  import excPkg::*;
#(
  parameter int PW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  excStrobe_t    strobe,
  input  logic [PW-1:0] curPc,
  input  logic [PW-1:0] nextPc,
  input  logic [SW-1:0] statusWdata,
  output logic          pcLoad,
  output logic [PW-1:0] pcOut,
  output logic          excTaken,
  output logic [2:0]    excCause,
  output logic [SW-1:0] status,
  output logic [PW-1:0] epc,
  output logic [SW-1:0] esr
);

  localparam logic [SW-1:0] SUP_MASK = SW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcLoad   <= 1'b0;
      pcOut    <= '0;
      excTaken <= 1'b0;
      excCause <= 3'd0;
      status   <= SUP_MASK;
      epc      <= '0;
      esr      <= '0;
    end else begin
      pcLoad   <= strobe.take || strobe.ret;
      excTaken <= strobe.take;
      excCause <= strobe.cause;
      if (strobe.take) begin
        epc    <= strobe.saveNext ? nextPc : curPc;
        esr    <= status;
        status <= status | SUP_MASK;
        pcOut  <= PW'(vectorOf(strobe.cause));
      end else if (strobe.ret) begin
        status <= esr;
        pcOut  <= epc;
      end else if (strobe.wrStatus) begin
        status <= statusWdata;
      end
    end
  end

  // R6
  enter_super_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (status[0] && pcLoad && excTaken));

  // R7
  restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ret |=> (status == $past(esr) && pcOut == $past(epc) && !excTaken));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> ($stable(epc) && $stable(esr)));

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import excPkg::*;
#(
  parameter int PW = 32,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          memValid,
  input  logic [PW-1:0] memAddr,
  input  logic [1:0]    memSize,
  input  logic          illegalInstr,
  input  logic          trapReq,
  input  logic          sysCall,
  input  logic          tickIrq,
  input  logic          eretReq,
  input  logic          statusWe,
  input  logic [SW-1:0] statusWdata,
  input  logic [PW-1:0] curPc,
  input  logic [PW-1:0] nextPc,
  output logic          pcLoad,
  output logic [PW-1:0] pcOut,
  output logic          excTaken,
  output logic [2:0]    excCause,
  output logic [SW-1:0] status,
  output logic [PW-1:0] epc,
  output logic [SW-1:0] esr
);

  excStrobe_t strobe;

  excCtrl #(.AW(PW)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .memValid(memValid), .memAddr(memAddr), .memSize(memSize),
    .illegalInstr(illegalInstr), .trapReq(trapReq), .sysCall(sysCall),
    .tickIrq(tickIrq), .eretReq(eretReq), .statusWe(statusWe),
    .strobe(strobe)
  );

  excState #(.PW(PW), .SW(SW)) i_state (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .curPc(curPc), .nextPc(nextPc), .statusWdata(statusWdata),
    .pcLoad(pcLoad), .pcOut(pcOut), .excTaken(excTaken), .excCause(excCause),
    .status(status), .epc(epc), .esr(esr)
  );

endmodule

// File: tb/test_exc_vector_unit.sv
module test_exc_vector_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memValid = 0;
  logic [31:0] memAddr = 0;
  logic [1:0]  memSize = 0;
  logic        illegalInstr = 0, trapReq = 0, sysCall = 0, tickIrq = 0, eretReq = 0;
  logic        statusWe = 0;
  logic [7:0]  statusWdata = 0;
  logic [31:0] curPc = 0, nextPc = 0;
  logic        pcLoad, excTaken;
  logic [31:0] pcOut, epc;
  logic [2:0]  excCause;
  logic [7:0]  status, esr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  exc_vector_unit i_exc_vector_unit (
    .clk(clk), .rstN(rstN), .memValid(memValid), .memAddr(memAddr), .memSize(memSize),
    .illegalInstr(illegalInstr), .trapReq(trapReq), .sysCall(sysCall), .tickIrq(tickIrq),
    .eretReq(eretReq), .statusWe(statusWe), .statusWdata(statusWdata),
    .curPc(curPc), .nextPc(nextPc), .pcLoad(pcLoad), .pcOut(pcOut), .excTaken(excTaken),
    .excCause(excCause), .status(status), .epc(epc), .esr(esr)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    memValid = 0; memAddr = 0; memSize = 0;
    illegalInstr = 0; trapReq = 0; sysCall = 0; tickIrq = 0; eretReq = 0;
    statusWe = 0; statusWdata = 0;
  endtask

  // inputs already set at a negedge: step one edge, sample, clear
  task automatic stepClear();
    @(posedge clk); #1;
  endtask

  task automatic endStep();
    @(negedge clk); clearIn();
  endtask

  task automatic expectExc(input string tag, input logic [2:0] c, input logic [31:0] vec,
                           input logic [31:0] savedPc);
    stepClear();
    check({tag, " pcLoad"}, 32'(pcLoad), 1);
    check({tag, " excTaken"}, 32'(excTaken), 1);
    check({tag, " cause"}, 32'(excCause), 32'(c));
    check({tag, " vector"}, pcOut, vec);
    check({tag, " epc"}, epc, savedPc);
    check({tag, " supervisor"}, 32'(status[0]), 1);
    endStep();
  endtask

  task automatic expectNone(input string tag);
    stepClear();
    check({tag, " no redirect"}, 32'(pcLoad), 0);
    endStep();
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] s, input logic [31:0] pc);
    memValid = 1; memAddr = a; memSize = s; curPc = pc; nextPc = pc + 4;
  endtask

  task automatic testReset();
    check("R8 status", 32'(status), 32'h01);
    check("R8 pcLoad", 32'(pcLoad), 0);
    check("R8 excTaken", 32'(excTaken), 0);
    check("R8 cause", 32'(excCause), 0);
    check("R8 epc", epc, 0);
    check("R8 esr", 32'(esr), 0);
  endtask

  task automatic testAlign();
    access(32'h0400_0010, 2'b10, 32'h100); expectNone("R1 aligned word");
    access(32'h0400_0012, 2'b10, 32'h104); expectExc("R1 word off2", 2, 32'h600, 32'h104);
    access(32'h0400_0011, 2'b11, 32'h108); expectExc("R1 size3 off1", 2, 32'h600, 32'h108);
    access(32'h0400_0013, 2'b01, 32'h10C); expectExc("R1 half odd", 2, 32'h600, 32'h10C);
    access(32'h0400_0012, 2'b01, 32'h110); expectNone("R1 half even");
    access(32'h0400_0013, 2'b00, 32'h114); expectNone("R1 byte odd");
  endtask

  task automatic testBus();
    access(32'h0300_0000, 2'b10, 32'h200); expectExc("R2 unpopulated", 1, 32'h200, 32'h200);
    access(32'h0003_0000, 2'b00, 32'h204); expectExc("R2 past rom", 1, 32'h200, 32'h204);
    access(32'h0002_FFFC, 2'b10, 32'h208); expectNone("R2 rom top");
    access(32'h0200_0FFF, 2'b00, 32'h20C); expectNone("R2 periph top");
    access(32'h0400_8001, 2'b10, 32'h210); expectExc("R3 bus over align", 1, 32'h200, 32'h210);
  endtask

  task automatic testSync();
    curPc = 32'h300; nextPc = 32'h304; illegalInstr = 1;
    expectExc("R4 illegal", 3, 32'h700, 32'h300);
    curPc = 32'h310; nextPc = 32'h314; trapReq = 1;
    expectExc("R4 trap", 4, 32'hE00, 32'h310);
    curPc = 32'h320; nextPc = 32'h324; sysCall = 1;
    expectExc("R5 syscall nextPc", 5, 32'hC00, 32'h324);
    curPc = 32'h330; nextPc = 32'h334; tickIrq = 1;
    expectExc("R4 tick", 6, 32'h500, 32'h330);
    curPc = 32'h340; nextPc = 32'h344; illegalInstr = 1; trapReq = 1; sysCall = 1; tickIrq = 1;
    expectExc("R3 illegal first", 3, 32'h700, 32'h340);
    curPc = 32'h350; nextPc = 32'h354; sysCall = 1; tickIrq = 1;
    expectExc("R3 syscall over tick", 5, 32'hC00, 32'h354);
    curPc = 32'h360; nextPc = 32'h364; trapReq = 1; sysCall = 1;
    expectExc("R3 trap over syscall", 4, 32'hE00, 32'h360);
    access(32'h0400_0002, 2'b10, 32'h370); illegalInstr = 1;
    expectExc("R3 align over illegal", 2, 32'h600, 32'h370);
  endtask

  task automatic testIgnored();
    memValid = 0; memAddr = 32'h0300_0003; memSize = 2'b10;
    stepClear();
    check("R10 no redirect", 32'(pcLoad), 0);
    check("R10 no taken", 32'(excTaken), 0);
    endStep();
  endtask

  task automatic testReturn();
    statusWe = 1; statusWdata = 8'hA4;
    stepClear(); check("R9 status write", 32'(status), 32'hA4); endStep();
    curPc = 32'h400; nextPc = 32'h404; sysCall = 1;
    stepClear();
    check("R6 esr saved", 32'(esr), 32'hA4);
    check("R6 status super", 32'(status), 32'hA5);
    check("R6 vector", pcOut, 32'hC00);
    endStep();
    eretReq = 1;
    stepClear();
    check("R7 status restored", 32'(status), 32'hA4);
    check("R7 pcLoad", 32'(pcLoad), 1);
    check("R7 not exc", 32'(excTaken), 0);
    check("R7 pcOut", pcOut, 32'h404);
    endStep();
    // return and tick in the same cycle
    curPc = 32'h500; nextPc = 32'h504; eretReq = 1; tickIrq = 1;
    stepClear();
    check("R9 tick wins vector", pcOut, 32'h500);
    check("R9 tick wins epc", epc, 32'h500);
    check("R9 esr user", 32'(esr), 32'hA4);
    check("R9 supervisor", 32'(status), 32'hA5);
    endStep();
    // status write loses to exception
    statusWe = 1; statusWdata = 8'h30; trapReq = 1; curPc = 32'h600; nextPc = 32'h604;
    stepClear();
    check("R9 write dropped", 32'(status), 32'hA5);
    check("R9 trap vector", pcOut, 32'hE00);
    endStep();
    stepClear();
    check("R6 pulse ends", 32'(pcLoad), 0);
    endStep();
  endtask

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    #1; testReset();
    @(negedge clk); rstN = 1;
    testAlign();
    testBus();
    testSync();
    testIgnored();
    testReturn();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule